// File: doc/BRIEF.md
# Dual-Channel Drive Permit Monitor

This block turns two independently evaluated safety channels into one motion permit for a servo axis. It receives a permit, an emergency-stop input and a travel-limit input from each channel. It also receives the torque-off status reported by each channel's power stage, the brake command with its feedback, a watchdog health bit and a reset request. It drives one inhibit line per channel. Both lines go high together whenever either channel asks for a stop, so a single healthy channel is always enough to remove torque.

Disagreement between the channels is tolerated for a short, parameterised skew window and becomes a fault only if it outlasts that window. Loss of watchdog health, a stop requested by both channels, a brake that does not follow its command, and a torque-off that is not confirmed all set a single fault latch. The latch records the first cause as a 4-bit code, together with the value of a free-running cycle counter. The latch holds the inhibits high until a reset request is accepted. A request is accepted only on its rising edge, and only when every input is back in a normal, consistent state. A request that does not meet these conditions is refused, and the refusal is reported by a one-cycle pulse.

Top module: `dual_permit_monitor`

## Requirements
- R1: Out of reset `fault_latched`, `reason`, `stamp` and `reset_refused` are all 0. `inhibit_a` and `inhibit_b` are both low only while both permits are high, no stop input is set and no fault is latched. A low permit on either channel raises both inhibits in the same cycle.
- R2: Permits that differ for `SKEW_CYC` consecutive clock edges latch reason code 1 (permit split). A shorter difference latches nothing.
- R3: An emergency-stop or limit input on either channel raises both inhibits in the same cycle. If both channels assert the emergency stop, code 2 is latched at the next edge. If both assert the limit, code 3 is latched at the next edge.
- R4: An emergency-stop or limit input asserted on one channel only, for `SKEW_CYC` consecutive edges, latches code 4 (stop-input split).
- R5: While a stop is commanded, both torque-off status inputs must be high within `STO_TMO` edges. Otherwise code 6 is latched. Confirmation that arrives sooner latches nothing.
- R6: A brake feedback (1 = engaged) that differs from the brake command (1 = engage) for `BRAKE_TMO` consecutive edges latches code 5. A shorter difference latches nothing.
- R7: A low `wdt_ok` latches code 7 at the next edge.
- R8: Once set, the latch and both inhibits stay high after the cause goes away, and `reason` keeps the first cause. When causes arrive in the same cycle, the code follows this priority: 7, 2, 3, 1, 4, 5, 6.
- R9: A rising edge of `reset_req` clears the latch only if all of these hold: the permits agree, no stop or limit input is set, the brake feedback equals the command, `wdt_ok` is high, and no cause is present. The clear happens at that edge, and the block records code 8 with that edge's timestamp. Holding the request high does not produce a second action.
- R10: A rising edge of `reset_req` while latched and failing the gate leaves the latch, `reason` and `stamp` unchanged, and pulses `reset_refused` for exactly one cycle.
- R11: `stamp` captures the free-running counter, which counts clock edges since reset was released, at the edge on which the latch sets or clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| permit_a | input | 1 | Channel A run permit |
| permit_b | input | 1 | Channel B run permit |
| estop_a | input | 1 | Channel A emergency stop, high = stop |
| estop_b | input | 1 | Channel B emergency stop, high = stop |
| limit_a | input | 1 | Channel A travel limit, high = reached |
| limit_b | input | 1 | Channel B travel limit, high = reached |
| sto_ok_a | input | 1 | Channel A torque-off active status |
| sto_ok_b | input | 1 | Channel B torque-off active status |
| brake_cmd | input | 1 | Brake command, 1 = engage |
| brake_fb | input | 1 | Brake feedback, 1 = engaged |
| wdt_ok | input | 1 | Watchdog healthy |
| reset_req | input | 1 | Latch clear request, acts on its rising edge |
| inhibit_a | output | 1 | Channel A torque inhibit |
| inhibit_b | output | 1 | Channel B torque inhibit |
| fault_latched | output | 1 | Critical fault latch |
| reason | output | 4 | First-cause code or clear code |
| stamp | output | TS_W | Counter value at the last latch or clear |
| reset_refused | output | 1 | One-cycle pulse on a refused reset |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is two latch causes arriving together. The bench drops `wdt_ok` and raises both emergency stops at the same edge, and expects watchdog code 7 rather than code 2.

The second pair is a reset request meeting a fresh cause. While the latch is already set, the bench raises `reset_req` at the same edge as a dual emergency stop. It expects a refusal pulse with the original code and timestamp preserved. Finally, a request held high across a new latch event must not clear it until the request is dropped and raised again.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    typedef enum logic [3:0] {
        RSN_NONE         = 4'd0,
        RSN_PERMIT_SPLIT = 4'd1,
        RSN_ESTOP        = 4'd2,
        RSN_LIMIT        = 4'd3,
        RSN_INPUT_SPLIT  = 4'd4,
        RSN_BRAKE        = 4'd5,
        RSN_STO          = 4'd6,
        RSN_WDT          = 4'd7,
        RSN_CLEARED      = 4'd8
    } reason_e;

    typedef struct packed {
        logic wdt;
        logic estop;
        logic limit;
        logic permit_split;
        logic input_split;
        logic brake;
        logic sto;
    } cause_t;

    // Highest priority first; one code even when several causes coincide.
    function automatic reason_e first_cause(cause_t c);
        reason_e r;
        if (c.wdt)               r = RSN_WDT;
        else if (c.estop)        r = RSN_ESTOP;
        else if (c.limit)        r = RSN_LIMIT;
        else if (c.permit_split) r = RSN_PERMIT_SPLIT;
        else if (c.input_split)  r = RSN_INPUT_SPLIT;
        else if (c.brake)        r = RSN_BRAKE;
        else if (c.sto)          r = RSN_STO;
        else                     r = RSN_NONE;
        return r;
    endfunction

    function automatic logic any_cause(cause_t c);
        return |c;
    endfunction

endpackage

// File: rtl/dpm_persist.sv
// Flags a condition that has held for LIMIT consecutive clock edges.
module dpm_persist #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic cond,
    output logic hit
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !cond) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit = cond && (cnt_q == LAST);
endmodule

// File: rtl/dpm_latch.sv
// First-cause fault latch with edge-triggered, condition-gated clear.
module dpm_latch
    import dpm_pkg::*;
#(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  cause_t          cause,
    input  logic            gate_ok,
    input  logic            reset_req,
    input  logic [TS_W-1:0] ts,
    output logic            latched,
    output reason_e         reason,
    output logic [TS_W-1:0] stamp,
    output logic            refused
);
    logic req_q;
    logic req_rise;
    logic cause_now;

    assign req_rise  = reset_req && !req_q;
    assign cause_now = any_cause(cause);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= 1'b0;
            latched <= 1'b0;
            reason  <= RSN_NONE;
            stamp   <= '0;
            refused <= 1'b0;
        end else begin
            req_q   <= reset_req;
            refused <= 1'b0;
            if (!latched) begin
                if (cause_now) begin
                    latched <= 1'b1;
                    reason  <= first_cause(cause);
                    stamp   <= ts;
                end
            end else if (req_rise) begin
                if (gate_ok && !cause_now) begin
                    latched <= 1'b0;
                    reason  <= RSN_CLEARED;
                    stamp   <= ts;
                end else begin
                    refused <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dual_permit_monitor.sv
module dual_permit_monitor
    import dpm_pkg::*;
#(
    parameter int SKEW_CYC  = 4,
    parameter int BRAKE_TMO = 16,
    parameter int STO_TMO   = 8,
    parameter int TS_W      = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            permit_a,
    input  logic            permit_b,
    input  logic            estop_a,
    input  logic            estop_b,
    input  logic            limit_a,
    input  logic            limit_b,
    input  logic            sto_ok_a,
    input  logic            sto_ok_b,
    input  logic            brake_cmd,
    input  logic            brake_fb,
    input  logic            wdt_ok,
    input  logic            reset_req,
    output logic            inhibit_a,
    output logic            inhibit_b,
    output logic            fault_latched,
    output logic [3:0]      reason,
    output logic [TS_W-1:0] stamp,
    output logic            reset_refused
);
    localparam int NPAIR  = 3;
    localparam int P_PERM = 0;
    localparam int P_STOP = 1;
    localparam int P_LIM  = 2;

    // Free-running timebase for evidence stamps.
    logic [TS_W-1:0] ts_q;
    always_ff @(posedge clk) begin
        if (rst) ts_q <= '0;
        else     ts_q <= ts_q + 1'b1;
    end

    // Channel agreement monitors, one per dual input pair.
    logic [NPAIR-1:0] split;
    logic [NPAIR-1:0] split_hit;
    assign split[P_PERM] = permit_a ^ permit_b;
    assign split[P_STOP] = estop_a ^ estop_b;
    assign split[P_LIM]  = limit_a ^ limit_b;

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        dpm_persist #(.LIMIT(SKEW_CYC)) u_skew (
            .clk  (clk),
            .rst  (rst),
            .cond (split[g]),
            .hit  (split_hit[g])
        );
    end

    // Stop demand from either channel, plus the latch itself.
    logic stop_req;
    logic stop_cmd;
    logic latched;
    assign stop_req = ~(permit_a & permit_b) | estop_a | estop_b | limit_a | limit_b;
    assign stop_cmd = stop_req | latched;

    logic brake_hit;
    logic sto_hit;

    dpm_persist #(.LIMIT(BRAKE_TMO)) u_brake (
        .clk  (clk),
        .rst  (rst),
        .cond (brake_cmd ^ brake_fb),
        .hit  (brake_hit)
    );

    dpm_persist #(.LIMIT(STO_TMO)) u_sto (
        .clk  (clk),
        .rst  (rst),
        .cond (stop_cmd & ~(sto_ok_a & sto_ok_b)),
        .hit  (sto_hit)
    );

    cause_t cause;
    always_comb begin
        cause.wdt          = ~wdt_ok;
        cause.estop        = estop_a & estop_b;
        cause.limit        = limit_a & limit_b;
        cause.permit_split = split_hit[P_PERM];
        cause.input_split  = split_hit[P_STOP] | split_hit[P_LIM];
        cause.brake        = brake_hit;
        cause.sto          = sto_hit;
    end

    logic gate_ok;
    assign gate_ok = wdt_ok && (permit_a == permit_b)
                   && !(estop_a || estop_b || limit_a || limit_b)
                   && (brake_fb == brake_cmd);

    reason_e reason_q;

    dpm_latch #(.TS_W(TS_W)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .cause     (cause),
        .gate_ok   (gate_ok),
        .reset_req (reset_req),
        .ts        (ts_q),
        .latched   (latched),
        .reason    (reason_q),
        .stamp     (stamp),
        .refused   (reset_refused)
    );

    assign inhibit_a     = stop_cmd;
    assign inhibit_b     = stop_cmd;
    assign fault_latched = latched;
    assign reason        = reason_q;
endmodule

// File: rtl/dpm_checker.sv
module dpm_checker
    import dpm_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       permit_a,
    input logic       permit_b,
    input logic       estop_a,
    input logic       estop_b,
    input logic       limit_a,
    input logic       limit_b,
    input logic       reset_req,
    input logic       inhibit_a,
    input logic       inhibit_b,
    input logic       fault_latched,
    input logic [3:0] reason,
    input logic       reset_refused
);
    AST_PERMIT_LOW_INHIBITS: assert property (@(posedge clk) disable iff (rst)
        (!permit_a || !permit_b) |-> (inhibit_a && inhibit_b)); // R1

    AST_STOP_INPUT_INHIBITS: assert property (@(posedge clk) disable iff (rst)
        (estop_a || estop_b || limit_a || limit_b) |-> (inhibit_a && inhibit_b)); // R3

    AST_LATCH_INHIBITS: assert property (@(posedge clk) disable iff (rst)
        fault_latched |-> (inhibit_a && inhibit_b)); // R8

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (fault_latched && !reset_req) |=> fault_latched); // R8

    AST_REASON_STABLE: assert property (@(posedge clk) disable iff (rst)
        (fault_latched && $past(fault_latched)) |-> $stable(reason)); // R8

    AST_CLEAR_CODE: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_latched) |-> (reason == 4'(RSN_CLEARED))); // R9

    AST_REFUSE_PULSE: assert property (@(posedge clk) disable iff (rst)
        reset_refused |=> !reset_refused); // R10

    AST_REFUSE_KEEPS_LATCH: assert property (@(posedge clk) disable iff (rst)
        reset_refused |-> fault_latched); // R10
endmodule

bind dual_permit_monitor dpm_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .permit_a      (permit_a),
    .permit_b      (permit_b),
    .estop_a       (estop_a),
    .estop_b       (estop_b),
    .limit_a       (limit_a),
    .limit_b       (limit_b),
    .reset_req     (reset_req),
    .inhibit_a     (inhibit_a),
    .inhibit_b     (inhibit_b),
    .fault_latched (fault_latched),
    .reason        (reason),
    .reset_refused (reset_refused)
);

// File: tb/sim_dual_permit_monitor.sv
module sim_dual_permit_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int SKEW       = 4;
    localparam int BRK        = 16;
    localparam int STO        = 8;
    localparam int TSW        = 16;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic permit_a = 0, permit_b = 0, estop_a = 0, estop_b = 0;
    logic limit_a = 0, limit_b = 0, sto_ok_a = 1, sto_ok_b = 1;
    logic brake_cmd = 0, brake_fb = 0, wdt_ok = 1, reset_req = 0;
    logic inhibit_a, inhibit_b, fault_latched, reset_refused;
    logic [3:0] reason;
    logic [TSW-1:0] stamp;

    int n_checks = 0;
    int n_fail   = 0;
    logic [TSW-1:0] cyc = '0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= '0;
        else     cyc <= cyc + 1'b1;
    end

    dual_permit_monitor #(
        .SKEW_CYC(SKEW), .BRAKE_TMO(BRK), .STO_TMO(STO), .TS_W(TSW)
    ) u0 (
        .clk(clk), .rst(rst),
        .permit_a(permit_a), .permit_b(permit_b),
        .estop_a(estop_a), .estop_b(estop_b),
        .limit_a(limit_a), .limit_b(limit_b),
        .sto_ok_a(sto_ok_a), .sto_ok_b(sto_ok_b),
        .brake_cmd(brake_cmd), .brake_fb(brake_fb),
        .wdt_ok(wdt_ok), .reset_req(reset_req),
        .inhibit_a(inhibit_a), .inhibit_b(inhibit_b),
        .fault_latched(fault_latched), .reason(reason),
        .stamp(stamp), .reset_refused(reset_refused)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_latch(input string tag, input logic [3:0] code, input logic [TSW-1:0] ts);
        check({tag, " latched"}, 32'(fault_latched), 32'd1);
        check({tag, " reason"}, 32'(reason), 32'(code));
        check({tag, " stamp"}, 32'(stamp), 32'(ts));
        check({tag, " inhibit"}, {30'd0, inhibit_a, inhibit_b}, 32'd3);
    endtask

    // Caller leaves inputs normal; request rises at this negedge.
    task automatic clear_fault(input string tag);
        logic [TSW-1:0] c;
        c = cyc;
        reset_req = 1'b1;
        tick(1);
        check({tag, " R9 cleared"}, 32'(fault_latched), 32'd0);
        check({tag, " R9 code"}, 32'(reason), 32'd8);
        check({tag, " R9 stamp"}, 32'(stamp), 32'(c));
        reset_req = 1'b0;
        tick(1);
    endtask

    task automatic t_reset_state();
        check("R1 reset latched", 32'(fault_latched), 32'd0);
        check("R1 reset reason", 32'(reason), 32'd0);
        check("R1 reset stamp", 32'(stamp), 32'd0);
        check("R1 reset refused", 32'(reset_refused), 32'd0);
        check("R1 idle inhibit", {30'd0, inhibit_a, inhibit_b}, 32'd3);
        permit_a = 1; permit_b = 1;
        #1;
        check("R1 run inhibit", {30'd0, inhibit_a, inhibit_b}, 32'd0);
        tick(2);
        check("R1 run no fault", 32'(fault_latched), 32'd0);
    endtask

    task automatic t_permit_split();
        logic [TSW-1:0] c;
        permit_b = 0;
        #1;
        check("R1 single permit low inhibits", {30'd0, inhibit_a, inhibit_b}, 32'd3);
        tick(SKEW - 1);
        permit_b = 1;
        tick(1);
        check("R2 short split tolerated", 32'(fault_latched), 32'd0);
        check("R2 short split inhibit released", 32'(inhibit_a), 32'd0);
        permit_b = 0;
        c = cyc;
        tick(SKEW);
        expect_latch("R2 permit split", 4'd1, c + TSW'(SKEW - 1));
        permit_b = 1;
        tick(3);
        expect_latch("R8 latch holds", 4'd1, c + TSW'(SKEW - 1));
        clear_fault("permit");
        check("R1 run after clear", 32'(inhibit_b), 32'd0);
    endtask

    task automatic t_estop_both();
        logic [TSW-1:0] c;
        estop_a = 1; estop_b = 1;
        c = cyc;
        #1;
        check("R3 estop inhibits at once", {30'd0, inhibit_a, inhibit_b}, 32'd3);
        tick(1);
        expect_latch("R3 estop", 4'd2, c);
        reset_req = 1;
        tick(1);
        check("R10 refused pulse", 32'(reset_refused), 32'd1);
        expect_latch("R10 refused keeps", 4'd2, c);
        tick(1);
        check("R10 pulse one cycle", 32'(reset_refused), 32'd0);
        estop_a = 0; estop_b = 0; reset_req = 0;
        tick(1);
        clear_fault("estop");
    endtask

    task automatic t_limit_both();
        logic [TSW-1:0] c;
        limit_a = 1; limit_b = 1;
        c = cyc;
        tick(1);
        expect_latch("R3 limit", 4'd3, c);
        limit_a = 0; limit_b = 0;
        tick(1);
        clear_fault("limit");
    endtask

    task automatic t_input_split();
        logic [TSW-1:0] c;
        limit_a = 1;
        c = cyc;
        #1;
        check("R3 single limit inhibits", {30'd0, inhibit_a, inhibit_b}, 32'd3);
        tick(SKEW - 1);
        check("R4 not yet", 32'(fault_latched), 32'd0);
        tick(1);
        expect_latch("R4 input split", 4'd4, c + TSW'(SKEW - 1));
        limit_a = 0;
        tick(1);
        clear_fault("split");
    endtask

    task automatic t_brake();
        logic [TSW-1:0] c;
        brake_cmd = 1; brake_fb = 0;
        tick(BRK - 1);
        brake_fb = 1;
        tick(1);
        check("R6 brake in time", 32'(fault_latched), 32'd0);
        brake_cmd = 0;
        c = cyc;
        tick(BRK);
        expect_latch("R6 brake mismatch", 4'd5, c + TSW'(BRK - 1));
        brake_fb = 0;
        tick(1);
        clear_fault("brake");
    endtask

    task automatic t_sto();
        logic [TSW-1:0] c;
        sto_ok_b = 0;
        tick(1);
        permit_a = 0; permit_b = 0;
        tick(STO - 1);
        sto_ok_b = 1;
        tick(1);
        check("R5 sto confirmed in time", 32'(fault_latched), 32'd0);
        permit_a = 1; permit_b = 1; sto_ok_b = 0;
        tick(1);
        permit_a = 0; permit_b = 0;
        c = cyc;
        tick(STO);
        expect_latch("R5 sto missing", 4'd6, c + TSW'(STO - 1));
        reset_req = 1;
        tick(1);
        check("R10 sto unconfirmed refuses", 32'(reset_refused), 32'd1);
        reset_req = 0; sto_ok_b = 1;
        tick(1);
        clear_fault("sto");
        permit_a = 1; permit_b = 1;
        tick(1);
    endtask

    task automatic t_wdt_priority();
        logic [TSW-1:0] c;
        wdt_ok = 0; estop_a = 1; estop_b = 1;
        c = cyc;
        tick(1);
        expect_latch("R7 R8 wdt over estop", 4'd7, c);
        estop_a = 0; estop_b = 0;
        tick(1);
        reset_req = 1;
        tick(1);
        check("R10 wdt low refuses", 32'(reset_refused), 32'd1);
        check("R11 stamp kept on refusal", 32'(stamp), 32'(c));
        reset_req = 0; wdt_ok = 1;
        tick(1);
        reset_req = 1; estop_a = 1; estop_b = 1;
        tick(1);
        check("R10 collision refused", 32'(reset_refused), 32'd1);
        expect_latch("R10 collision keeps", 4'd7, c);
        reset_req = 0; estop_a = 0; estop_b = 0;
        tick(1);
        clear_fault("wdt");
    endtask

    task automatic t_held_request();
        logic [TSW-1:0] c;
        reset_req = 1;
        tick(1);
        wdt_ok = 0;
        c = cyc;
        tick(1);
        wdt_ok = 1;
        tick(3);
        expect_latch("R9 held request no action", 4'd7, c);
        check("R9 held request no refusal", 32'(reset_refused), 32'd0);
        reset_req = 0;
        tick(1);
        clear_fault("held");
    endtask

    initial begin
        tick(3);
        rst = 0;
        tick(2);
        t_reset_state();
        t_permit_split();
        t_estop_both();
        t_limit_both();
        t_input_split();
        t_brake();
        t_sto();
        t_wdt_priority();
        t_held_request();
        done = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule